// File: doc/BRIEF.md
# Sample Rate PLL Divider Encoder

This block turns a requested audio sample rate, given in Hz, into the 12-bit control word that programs a PLL running from a 28.224 MHz reference. The PLL's divider value is not written as a plain binary count. It is packed into a short prescale field and a 9-bit mantissa. At the two coarsest ranges the low bits of the divider are dropped, so the rate the PLL actually produces can differ slightly from the rate that was asked for. The block also returns that achieved rate, so software can report it.

A request is a one-cycle `start_i` pulse with `freq_i` valid in the same cycle. The block computes the result with one restoring divider that produces one quotient bit per cycle. It runs the divider twice: first to find the raw divider, then to find the achieved rate. While `busy_o` is high the block accepts no new request. A `start_i` pulse during that time is dropped, not queued, so the caller must wait for `done_o` before issuing the next request. `done_o` pulses for one cycle when the results are ready. `err_o` qualifies that pulse. The high and low bytes of the word are held on separate outputs, one for each PLL register write.

Top module: `pll_rate_encoder`

## Requirements
- R1: After reset, `done_o`, `busy_o` and `err_o` are 0, and `word_hi_o`, `word_lo_o` and `rate_o` are all 0.
- R2: A request with `freq_i` below 6900 or above 219000 gives a one-cycle `done_o` with `err_o`=1 in the cycle after `start_i`. `busy_o` stays low, and `word_hi_o`, `word_lo_o` and `rate_o` keep their previous values. The values 6900 and 219000 themselves are accepted.
- R3: For an accepted request, the raw divider is D = (56448000 / freq - 1) / 2, with both divisions truncating.
- R4: If D < 0x100, the word is D + 0xC00. Otherwise, if D < 0x200, the word is D + 0x800. Otherwise, if D < 0x400, the word is D & 0x1FF.
- R5: If 0x400 <= D < 0x800, the word is ((D >> 1) & 0x1FF) + 0x200 and the adjusted divider is D with bit 0 cleared. If D >= 0x800, the word is ((D >> 2) & 0x1FF) + 0x400 and the adjusted divider is D with bits 1:0 cleared. In all other ranges the adjusted divider equals D.
- R6: `rate_o` = 28224000 / (adjusted divider + 1), truncated. For every accepted request it lies between 6900 and 219000.
- R7: `word_lo_o` holds bits 7:0 of the word. `word_hi_o` holds bits 11:8 of the word in its low nibble, and its upper nibble is zero.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The running request completes with its own result, and no extra `done_o` follows.
- R9: `busy_o` rises in the cycle after an accepted in-range request. It falls in the same cycle that `done_o` rises. `done_o` lasts exactly one cycle, and the outputs do not change while `busy_o` is high.
- R10: An accepted in-range request completes within 2*NUM_W+8 cycles of its `start_i`, where NUM_W is the dividend width (26 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request pulse |
| freq_i | input | RATE_W (18) | Requested sample rate in Hz |
| busy_o | output | 1 | A request is in progress; `start_i` is ignored |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last completion was an out-of-range request |
| word_hi_o | output | 8 | Control word bits 11:8, zero-extended |
| word_lo_o | output | 8 | Control word bits 7:0 |
| rate_o | output | RATE_W (18) | Achieved sample rate in Hz |

## Verification
The assertions assume that `start_i` is a clean pulse sampled only on clock edges. They also assume `freq_i` is held steady in the cycle it is sampled, so the divider never sees a zero divisor. The range check screens out zero before any division starts. The stimulus drives `start_i` and `freq_i` on falling edges and lowers `start_i` after one cycle. Every in-range request the bench sends leaves the achieved rate inside the band that the rate-range property expects.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_COARSE = 2'd1,
    PH_FINE   = 2'd2
  } phase_e;

  // Range thresholds on the raw divider and the prefixes they select
  localparam int unsigned BAND_DIRECT_LIM = 'h100;
  localparam int unsigned BAND_MID_LIM    = 'h200;
  localparam int unsigned BAND_PLAIN_LIM  = 'h400;
  localparam int unsigned BAND_HALF_LIM   = 'h800;

  localparam int unsigned PFX_DIRECT = 'hC00;
  localparam int unsigned PFX_MID    = 'h800;
  localparam int unsigned PFX_HALF   = 'h200;
  localparam int unsigned PFX_QUART  = 'h400;

  localparam int unsigned MANT_MASK  = 'h1FF;

endpackage

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int NUM_W = 26,
  parameter int DEN_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [NUM_W-1:0] quot_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] shreg_q;
  logic [DEN_W-1:0] rem_q;
  logic [DEN_W-1:0] den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;

  logic [DEN_W:0]   trial;
  logic [DEN_W:0]   diff;
  logic             fits;

  // One restoring step: bring down the next dividend bit, subtract if it fits
  always_comb begin
    trial = {rem_q, shreg_q[NUM_W-1]};
    diff  = trial - {1'b0, den_q};
    fits  = ~diff[DEN_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg_q <= '0;
      rem_q   <= '0;
      den_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start_i) begin
        shreg_q <= num_i;
        rem_q   <= '0;
        den_q   <= den_i;
        cnt_q   <= CNT_W'(NUM_W);
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        rem_q   <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        shreg_q <= {shreg_q[NUM_W-2:0], fits};
        cnt_q   <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quot_o = shreg_q;

endmodule

// File: rtl/pll_word_encoder.sv
module pll_word_encoder
  import pll_div_pkg::*;
#(
  parameter int RAW_W = 12
) (
  input  logic [RAW_W-1:0] raw_i,
  output logic [RAW_W-1:0] word_o,
  output logic [RAW_W-1:0] adj_o
);
  logic [RAW_W-1:0] half_mant;
  logic [RAW_W-1:0] quart_mant;
  logic [RAW_W-1:0] plain_mant;

  always_comb begin
    plain_mant = raw_i & RAW_W'(MANT_MASK);
    half_mant  = (raw_i >> 1) & RAW_W'(MANT_MASK);
    quart_mant = (raw_i >> 2) & RAW_W'(MANT_MASK);

    if (raw_i < RAW_W'(BAND_DIRECT_LIM)) begin
      word_o = raw_i + RAW_W'(PFX_DIRECT);
      adj_o  = raw_i;
    end else if (raw_i < RAW_W'(BAND_MID_LIM)) begin
      word_o = raw_i + RAW_W'(PFX_MID);
      adj_o  = raw_i;
    end else if (raw_i < RAW_W'(BAND_PLAIN_LIM)) begin
      word_o = plain_mant;
      adj_o  = raw_i;
    end else if (raw_i < RAW_W'(BAND_HALF_LIM)) begin
      word_o = half_mant + RAW_W'(PFX_HALF);
      adj_o  = {raw_i[RAW_W-1:1], 1'b0};
    end else begin
      word_o = quart_mant + RAW_W'(PFX_QUART);
      adj_o  = {raw_i[RAW_W-1:2], 2'b00};
    end
  end

endmodule

// File: rtl/pll_rate_encoder.sv
module pll_rate_encoder
  import pll_div_pkg::*;
#(
  parameter int REF_HZ = 28224000,
  parameter int MIN_HZ = 6900,
  parameter int MAX_HZ = 219000,
  parameter int RATE_W = 18,
  parameter int RAW_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [RATE_W-1:0] freq_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [7:0]        word_hi_o,
  output logic [7:0]        word_lo_o,
  output logic [RATE_W-1:0] rate_o
);
  localparam int NUM_W = $clog2(2 * REF_HZ + 1);

  phase_e            phase_q;
  logic              div_start;
  logic [NUM_W-1:0]  div_num;
  logic [RATE_W-1:0] div_den;
  logic              div_busy;
  logic              div_done;
  logic [NUM_W-1:0]  div_quot;

  logic [NUM_W-1:0]  quot_m1;
  logic [RAW_W-1:0]  raw_div;
  logic [RAW_W-1:0]  enc_word;
  logic [RAW_W-1:0]  enc_adj;
  logic [RAW_W-1:0]  word_pend_q;

  logic              in_range;
  logic              req_ok;

  logic [7:0]        hi_q;
  logic [7:0]        lo_q;
  logic [RATE_W-1:0] rate_q;
  logic              err_q;
  logic              done_q;

  assign in_range = (freq_i >= RATE_W'(MIN_HZ)) && (freq_i <= RATE_W'(MAX_HZ));
  assign req_ok   = (phase_q == PH_IDLE) && start_i && in_range;

  // First pass divides twice the reference by the request, second pass
  // divides the reference by the adjusted divider plus one.
  always_comb begin
    div_start = req_ok || ((phase_q == PH_COARSE) && div_done);
    if (phase_q == PH_IDLE) begin
      div_num = NUM_W'(2 * REF_HZ);
      div_den = freq_i;
    end else begin
      div_num = NUM_W'(REF_HZ);
      div_den = RATE_W'(enc_adj) + RATE_W'(1);
    end
  end

  assign quot_m1 = div_quot - NUM_W'(1);
  assign raw_div = quot_m1[RAW_W:1];

  restoring_divider #(
    .NUM_W (NUM_W),
    .DEN_W (RATE_W)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (div_start),
    .num_i   (div_num),
    .den_i   (div_den),
    .busy_o  (div_busy),
    .done_o  (div_done),
    .quot_o  (div_quot)
  );

  pll_word_encoder #(
    .RAW_W (RAW_W)
  ) u_enc (
    .raw_i  (raw_div),
    .word_o (enc_word),
    .adj_o  (enc_adj)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      word_pend_q <= '0;
      hi_q        <= '0;
      lo_q        <= '0;
      rate_q      <= '0;
      err_q       <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            if (in_range) begin
              phase_q <= PH_COARSE;
            end else begin
              err_q  <= 1'b1;
              done_q <= 1'b1;
            end
          end
        end
        PH_COARSE: begin
          if (div_done) begin
            word_pend_q <= enc_word;
            phase_q     <= PH_FINE;
          end
        end
        PH_FINE: begin
          if (div_done) begin
            hi_q    <= 8'(word_pend_q >> 8);
            lo_q    <= word_pend_q[7:0];
            rate_q  <= div_quot[RATE_W-1:0];
            err_q   <= 1'b0;
            done_q  <= 1'b1;
            phase_q <= PH_IDLE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o    = (phase_q != PH_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign word_hi_o = hi_q;
  assign word_lo_o = lo_q;
  assign rate_o    = rate_q;

endmodule

// File: rtl/pll_rate_encoder_chk.sv
module pll_rate_encoder_chk #(
  parameter int MIN_HZ = 6900,
  parameter int MAX_HZ = 219000,
  parameter int RATE_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [7:0]        word_hi_o,
  input logic [7:0]        word_lo_o,
  input logic [RATE_W-1:0] rate_o
);

  // R9: completion is never reported while a request is still in flight
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R9: the end of a busy period coincides with the completion pulse
  a_r9_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R9 / R8: results are frozen while a request runs
  a_r8_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o ? ($stable(rate_o) && $stable(word_hi_o) && $stable(word_lo_o)) : 1'b1));

  // R2: a rejected request leaves the previous results untouched
  a_r2_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> ((done_o && err_o) ?
      ($stable(rate_o) && $stable(word_hi_o) && $stable(word_lo_o)) : 1'b1));

  // R6: every successful result lands inside the supported band
  a_r6_rate_range: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (rate_o >= RATE_W'(MIN_HZ) && rate_o <= RATE_W'(MAX_HZ)));

  // R7: the high byte carries only four word bits
  a_r7_hi_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (word_hi_o[7:4] == 4'd0));

endmodule

bind pll_rate_encoder pll_rate_encoder_chk #(
  .MIN_HZ (MIN_HZ),
  .MAX_HZ (MAX_HZ),
  .RATE_W (RATE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .word_hi_o (word_hi_o),
  .word_lo_o (word_lo_o),
  .rate_o    (rate_o)
);

// File: tb/tb_pll_rate_encoder.sv
module tb_pll_rate_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int RATE_W     = 18;
  localparam int LAT_MAX    = 2 * 26 + 8;
  localparam int NVEC       = 12;

  // freq, expected word, expected achieved rate, expected error
  localparam int VEC_FREQ [NVEC] = '{48000, 44100, 192000, 96000, 8000, 22050,
                                     6900, 219000, 110465, 110035, 6899, 219001};
  localparam int VEC_WORD [NVEC] = '{'h04B, 'h07F, 'hC92, 'h925, 'h571, 'h27F,
                                     'h5FE, 'hC80, 'hCFF, 'h900, 0, 0};
  localparam int VEC_RATE [NVEC] = '{48000, 44100, 192000, 96000, 8006, 22067,
                                     6902, 218790, 110250, 109821, 0, 0};
  localparam int VEC_ERR  [NVEC] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [RATE_W-1:0] freq_i = '0;
  logic              busy_o, done_o, err_o;
  logic [7:0]        word_hi_o, word_lo_o;
  logic [RATE_W-1:0] rate_o;

  int checks = 0;
  int errors = 0;
  int lat;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_rate_encoder dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .freq_i(freq_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .word_hi_o(word_hi_o), .word_lo_o(word_lo_o), .rate_o(rate_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pulse start for one cycle, then wait for done; lat holds negedges counted
  task automatic request(input int f);
    freq_i  = RATE_W'(f);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int prev_word;
    int prev_rate;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!done_o && !busy_o && !err_o, "R1 flags", {done_o, busy_o, err_o}, 0);
    check(word_hi_o == 0 && word_lo_o == 0 && rate_o == 0, "R1 outputs", rate_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    prev_word = 0;
    prev_rate = 0;
    for (int i = 0; i < NVEC; i++) begin
      request(VEC_FREQ[i]);
      check(done_o == 1'b1, "R10 completion", lat, LAT_MAX);
      check(lat <= LAT_MAX, "R10 latency", lat, LAT_MAX);
      check(err_o == VEC_ERR[i][0], "R2 err flag", err_o, VEC_ERR[i]);
      if (VEC_ERR[i] != 0) begin
        check(lat == 1, "R2 err timing", lat, 1);
        check({word_hi_o, word_lo_o} == 16'(prev_word), "R2 word unchanged",
              {word_hi_o, word_lo_o}, prev_word);
        check(rate_o == RATE_W'(prev_rate), "R2 rate unchanged", rate_o, prev_rate);
      end else begin
        // R3 R4 R5: word from range encoding of the raw divider
        check(word_lo_o == 8'(VEC_WORD[i]), "R4 R5 word low byte", word_lo_o, VEC_WORD[i] & 'hFF);
        // R7: high byte carries bits 11:8, zero upper nibble
        check(word_hi_o == 8'(VEC_WORD[i] >> 8), "R7 word high byte", word_hi_o, VEC_WORD[i] >> 8);
        // R6: achieved rate
        check(rate_o == RATE_W'(VEC_RATE[i]), "R6 achieved rate", rate_o, VEC_RATE[i]);
        prev_word = VEC_WORD[i];
        prev_rate = VEC_RATE[i];
      end
      @(negedge clk);
      // R9: done lasts one cycle
      check(done_o == 1'b0, "R9 done width", done_o, 0);
    end

    // R9: busy rises the cycle after an accepted request; R8: late start ignored
    freq_i  = RATE_W'(48000);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R9 busy rise", busy_o, 1);
    repeat (5) @(negedge clk);
    freq_i  = RATE_W'(8000);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    check(rate_o == RATE_W'(48000), "R8 busy start ignored rate", rate_o, 48000);
    check(word_lo_o == 8'h4B && word_hi_o == 8'h00, "R8 busy start ignored word",
          {word_hi_o, word_lo_o}, 'h04B);
    begin
      int extra = 0;
      for (int k = 0; k < 80; k++) begin
        @(negedge clk);
        if (done_o || busy_o) extra++;
      end
      check(extra == 0, "R8 no extra completion", extra, 0);
    end

    // R3 R5: quarter band right after an error keeps the error cleared
    request(6899);
    check(err_o == 1'b1, "R2 low bound reject", err_o, 1);
    @(negedge clk);
    request(8000);
    check(err_o == 1'b0 && rate_o == RATE_W'(8006), "R3 R5 after error", rate_o, 8006);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule